// File: doc/BRIEF.md
# Video Source Selector with Two-Wire Control Port

This block is the digital control side of an analog video crossbar. A host sets it over a two-wire serial bus (I2C, standard mode, SCL up to 100 kHz). The block answers to one 7-bit device address. The top six address bits are fixed and the lowest bit comes from a board strap. It holds one 8-bit control byte, and the top three bits of that byte choose a source pair. Output 1 takes one of five composite inputs or one of three luma inputs. Output 2 takes one of three chroma inputs. The block drives one-hot enables for the analog switch cells.

A power-enable input mutes both outputs when it is low. A board that leaves this input floating must pull it low. The sync-detect tap has its own source choice, made by a separate pin, and it keeps running while the outputs are muted.

Both bus lines are sampled by a system clock that runs at least 16 times faster than SCL. START and STOP are seen as SDA edges while SCL is high. The data line is open-drain, so the block drives it only through a pull-low enable.

Top module: `vidsel_i2c`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 1001010 plus the strap bit, read/write flag in bit 0, sent MSB first. With the strap low this means 0x94 for write and 0x95 for read. With the strap high it means 0x96 and 0x97. The acknowledge is a low on SDA during the ninth SCL pulse.
- R2: After a matching write address, the block acknowledges one data byte and stores all eight bits in the control register.
- R3: After reset the control register is 0x00, so with power enabled `sel1_oh` = 0x01 and `sel2_oh` = 0x1. SDA is released.
- R4: With power enabled and select field (register bits 7:5) equal to 0 to 4, `sel1_oh` has only bit `code` set (composite inputs 1 to 5 on bits 0 to 4), and `sel2_oh` = 0x1 (chroma 1).
- R5: With power enabled and select field 5, 6 or 7, `sel1_oh` has only bit 5, 6 or 7 set (luma 1, 2 or 3). `sel2_oh` then has only bit 0, 1 or 2 set (chroma 1, 2 or 3).
- R6: While `pwr_on` is low, `sel1_oh` and `sel2_oh` are all zero. A write made during mute still updates the register.
- R7: `det_tap` is 2'b10 (luma 1) when `det_pick` is high and 2'b01 (composite 1) when it is low, whatever the power state.
- R8: A matching read returns the control register MSB first. After a master ACK it sends the byte again. After a master NACK it keeps SDA released until the next START. SDA changes only while SCL is low.
- R9: A new value reaches the outputs only after the falling SCL edge that ends the data acknowledge. A transfer cut short by STOP before that edge leaves the register unchanged.
- R10: A repeated START at any point restarts address decoding, and a complete transfer that follows it takes effect.
- R11: On an address mismatch the block does not acknowledge and ignores the bus until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| addr_strap | input | 1 | Board strap for address bit 0 |
| pwr_on | input | 1 | High: switch active; low: both outputs muted |
| det_pick | input | 1 | Sync-detect source: high luma 1, low composite 1 |
| sel1_oh | output | 8 | One-hot enable for output 1: bits 0-4 composite 1-5, bits 5-7 luma 1-3 |
| sel2_oh | output | 3 | One-hot enable for output 2: chroma 1-3 |
| det_tap | output | 2 | Sync-detect source: bit 0 composite 1, bit 1 luma 1 |

## Verification
The hardest situations to reach from the ports are transfers that break off part-way. Examples are a STOP in the middle of a data byte, and a repeated START in the middle of a data byte followed by a fresh full write. In both cases the outcome can only be seen as outputs that did not change. The bench builds these transfers from primitives that send a given number of bits, then places the STOP or START at the chosen point. Read-back checks SDA bit by bit, both at a master ACK that forces the byte to repeat and at the NACK that must leave the line released.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDAT,
      ST_WACK,
      ST_RDAT,
      ST_RACK,
      ST_SKIP
   } bus_st_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } bus_ev_t;

endpackage

// File: rtl/vsel_sync.sv
module vsel_sync #(
   parameter int             STAGES  = 2,
   parameter int             W       = 2,
   parameter logic [W-1:0]   RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("vsel_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("vsel_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/vsel_bus_edge.sv
module vsel_bus_edge
   import vsel_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_s,
   input  logic    sda_s,
   output bus_ev_t ev
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   always_comb begin
      ev.start = scl_s & scl_d &  sda_d & ~sda_s;
      ev.stop  = scl_s & scl_d & ~sda_d &  sda_s;
      ev.rise  =  scl_s & ~scl_d;
      ev.fall  = ~scl_s &  scl_d;
      ev.sda   = sda_s;
   end
endmodule

// File: rtl/vsel_i2c_slave.sv
module vsel_i2c_slave
   import vsel_pkg::*;
#(
   parameter int              DATA_W  = 8,
   parameter int              ID_HI_W = 6,
   parameter logic [ID_HI_W-1:0] ID_HI = 6'b100101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ev_t           ev,
   input  logic              strap,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              sda_oe
);
   localparam int CW = $clog2(DATA_W + 1);
   localparam logic [CW-1:0] FULL = CW'(DATA_W);

   if (ID_HI_W + 2 != DATA_W) begin : g_bad_id
      $error("vsel_i2c_slave: ID_HI_W + strap + rw must fill one byte");
   end

   bus_st_e             st;
   logic [CW-1:0]       cnt;
   logic [DATA_W-1:0]   shreg;
   logic                rnw;
   logic                mack;
   logic [DATA_W-2:0]   dev_id;

   assign dev_id = {ID_HI, strap};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         shreg  <= '0;
         ctrl_q <= '0;
         sda_oe <= 1'b0;
         rnw    <= 1'b0;
         mack   <= 1'b0;
      end else if (ev.start) begin
         st     <= ST_ADDR;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else if (ev.stop) begin
         st     <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         unique case (st)
            ST_ADDR, ST_WDAT: begin
               if (ev.rise && cnt != FULL) begin
                  shreg <= {shreg[DATA_W-2:0], ev.sda};
                  cnt   <= cnt + 1'b1;
               end else if (ev.fall && cnt == FULL) begin
                  if (st == ST_WDAT) begin
                     sda_oe <= 1'b1;
                     st     <= ST_WACK;
                  end else if (shreg[DATA_W-1:1] == dev_id) begin
                     sda_oe <= 1'b1;
                     rnw    <= shreg[0];
                     st     <= ST_AACK;
                  end else begin
                     st <= ST_SKIP;
                  end
               end
            end
            ST_AACK: begin
               if (ev.fall) begin
                  cnt <= '0;
                  if (rnw) begin
                     shreg  <= ctrl_q;
                     sda_oe <= ~ctrl_q[DATA_W-1];
                     st     <= ST_RDAT;
                  end else begin
                     sda_oe <= 1'b0;
                     st     <= ST_WDAT;
                  end
               end
            end
            ST_WACK: begin
               if (ev.fall) begin
                  sda_oe <= 1'b0;
                  ctrl_q <= shreg;
                  st     <= ST_SKIP;
               end
            end
            ST_RDAT: begin
               if (ev.rise) begin
                  cnt <= cnt + 1'b1;
               end else if (ev.fall) begin
                  if (cnt == FULL) begin
                     sda_oe <= 1'b0;
                     st     <= ST_RACK;
                  end else begin
                     shreg  <= {shreg[DATA_W-2:0], 1'b0};
                     sda_oe <= ~shreg[DATA_W-2];
                  end
               end
            end
            ST_RACK: begin
               if (ev.rise) begin
                  mack <= ~ev.sda;
               end else if (ev.fall) begin
                  if (mack) begin
                     cnt    <= '0;
                     shreg  <= ctrl_q;
                     sda_oe <= ~ctrl_q[DATA_W-1];
                     st     <= ST_RDAT;
                  end else begin
                     st <= ST_SKIP;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/vsel_route.sv
module vsel_route #(
   parameter int SEL_W = 3,
   parameter int N1    = 8,
   parameter int N2    = 3
) (
   input  logic [SEL_W-1:0] code,
   input  logic             pwr_on,
   input  logic             det_pick,
   output logic [N1-1:0]    sel1_oh,
   output logic [N2-1:0]    sel2_oh,
   output logic [1:0]       det_tap
);
   localparam int FIRST_PAIR = N1 - N2;

   if (N1 != (1 << SEL_W)) begin : g_bad_n1
      $error("vsel_route: N1 must equal 2**SEL_W");
   end
   if (N2 < 1 || N2 >= N1) begin : g_bad_n2
      $error("vsel_route: N2 must lie in 1..N1-1");
   end

   for (genvar i = 0; i < N1; i++) begin : g_out1
      assign sel1_oh[i] = pwr_on && (code == SEL_W'(i));
   end

   for (genvar j = 0; j < N2; j++) begin : g_out2
      if (j == 0) begin : g_shared
         assign sel2_oh[j] = pwr_on && (code <= SEL_W'(FIRST_PAIR));
      end else begin : g_paired
         assign sel2_oh[j] = pwr_on && (code == SEL_W'(FIRST_PAIR + j));
      end
   end

   assign det_tap = {det_pick, ~det_pick};
endmodule

// File: rtl/vidsel_i2c.sv
module vidsel_i2c #(
   parameter int   DATA_W      = 8,
   parameter int   SEL_W       = 3,
   parameter int   N1          = 8,
   parameter int   N2          = 3,
   parameter int   SYNC_STAGES = 2,
   parameter logic [DATA_W-3:0] ID_HI = 6'b100101
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   input  logic          addr_strap,
   input  logic          pwr_on,
   input  logic          det_pick,
   output logic [N1-1:0] sel1_oh,
   output logic [N2-1:0] sel2_oh,
   output logic [1:0]    det_tap
);
   import vsel_pkg::*;

   if (SEL_W > DATA_W) begin : g_bad_sel
      $error("vidsel_i2c: select field wider than control byte");
   end

   logic [1:0]        bus_s;
   bus_ev_t           ev;
   logic [DATA_W-1:0] ctrl_q;

   vsel_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
   );

   vsel_bus_edge u_edge (
      .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]), .ev(ev)
   );

   vsel_i2c_slave #(.DATA_W(DATA_W), .ID_HI_W(DATA_W-2), .ID_HI(ID_HI)) u_slave (
      .clk(clk), .rst_n(rst_n), .ev(ev), .strap(addr_strap),
      .ctrl_q(ctrl_q), .sda_oe(sda_oe)
   );

   vsel_route #(.SEL_W(SEL_W), .N1(N1), .N2(N2)) u_route (
      .code(ctrl_q[DATA_W-1 -: SEL_W]), .pwr_on(pwr_on), .det_pick(det_pick),
      .sel1_oh(sel1_oh), .sel2_oh(sel2_oh), .det_tap(det_tap)
   );
endmodule

// File: rtl/vidsel_i2c_chk.sv
module vidsel_i2c_chk #(
   parameter int N1 = 8,
   parameter int N2 = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_i,
   input logic          sda_oe,
   input logic          pwr_on,
   input logic          det_pick,
   input logic [N1-1:0] sel1_oh,
   input logic [N2-1:0] sel2_oh,
   input logic [1:0]    det_tap
);
   // R6: muted outputs
   a_r6_mute: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |-> (sel1_oh == '0 && sel2_oh == '0));

   // R4, R5: exactly one source per output while active
   a_r4_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_on |-> ($countones(sel1_oh) == 1 && $countones(sel2_oh) == 1));

   // R5: luma n pairs with chroma n
   a_r5_pairing: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on && sel1_oh[N1-1 -: N2] != '0) |-> (sel2_oh == sel1_oh[N1-1 -: N2]));

   // R4: composite sources keep chroma 1
   a_r4_chroma_one: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on && sel1_oh[N1-N2-1:0] != '0) |-> (sel2_oh == N2'(1)));

   // R7: detect tap independent of power
   a_r7_det_tap: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(det_tap) && det_tap[1] == det_pick && det_tap != 2'b00);

   // R9: selection only moves while SCL is low (after the ACK falling edge)
   a_r9_commit_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on && $past(pwr_on) && sel1_oh != $past(sel1_oh)) |-> !scl_i);

   // R8: SDA is pulled only while SCL is low
   a_r8_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);
endmodule

bind vidsel_i2c vidsel_i2c_chk #(.N1(N1), .N2(N2)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .pwr_on(pwr_on),
   .det_pick(det_pick), .sel1_oh(sel1_oh), .sel2_oh(sel2_oh), .det_tap(det_tap)
);

// File: tb/vidsel_i2c_test.sv
`timescale 1ns/1ps
module vidsel_i2c_test;
   localparam int Q     = 25;
   localparam int LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic strap = 1'b0, pwr = 1'b1, det = 1'b0;
   logic sda_oe;
   logic [7:0] sel1;
   logic [2:0] sel2;
   logic [1:0] dtap;
   logic sda_bus;

   int tests = 0, fails = 0, cyc = 0;
   int commit_cyc = -100;
   int exp_reg = 0;
   bit done = 0;

   always #5 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   vidsel_i2c uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
      .addr_strap(strap), .pwr_on(pwr), .det_pick(det),
      .sel1_oh(sel1), .sel2_oh(sel2), .det_tap(dtap)
   );

   function automatic int exp1(int r, bit p);
      int code = (r >> 5) & 7;
      return p ? (1 << code) : 0;
   endfunction
   function automatic int exp2(int r, bit p);
      int code = (r >> 5) & 7;
      if (!p) return 0;
      return (code < 5) ? 1 : (1 << (code - 5));
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   // per-clock reference comparison (R4, R5, R6, R7)
   always @(negedge clk) begin
      if (rst_n && !done && (cyc - commit_cyc) > 8) begin
         check(sel1 == 8'(exp1(exp_reg, pwr)), "R4/R5/R6 sel1", sel1, exp1(exp_reg, pwr));
         check(sel2 == 3'(exp2(exp_reg, pwr)), "R4/R5/R6 sel2", sel2, exp2(exp_reg, pwr));
         check(dtap == (det ? 2'b10 : 2'b01), "R7 det_tap", dtap, det ? 2 : 1);
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > LIMIT && !done) begin
         fails++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, LIMIT);
         finish_run();
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      sda_m = 1; tick(Q); scl_m = 1; tick(Q);
      sda_m = 0; tick(Q); scl_m = 0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
   endtask

   task automatic send_bits(logic [7:0] b, int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; tick(Q); scl_m = 1; tick(2 * Q); scl_m = 0; tick(Q);
      end
   endtask

   task automatic send_byte(logic [7:0] b, output bit ack, input bit is_commit, input int val);
      send_bits(b, 8);
      sda_m = 1; tick(Q); scl_m = 1; tick(Q);
      ack = (sda_bus == 1'b0);
      tick(Q); scl_m = 0;
      if (is_commit && ack) begin
         exp_reg = val;
         commit_cyc = cyc;
      end
      tick(Q);
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit mack);
      sda_m = 1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q); scl_m = 1; tick(Q); b[i] = sda_bus; tick(Q); scl_m = 0; tick(Q);
      end
      sda_m = !mack; tick(Q); scl_m = 1; tick(2 * Q); scl_m = 0; tick(Q);
      sda_m = 1;
   endtask

   function automatic bit addr_hit(logic [7:0] a);
      return a[7:1] == {6'b100101, strap};
   endfunction

   task automatic write_reg(logic [7:0] a, logic [7:0] d, string req);
      bit ak, dk;
      bit hit = addr_hit(a) && !a[0];
      bus_start();
      send_byte(a, ak, 0, 0);
      check(ak == hit, {req, " addr ack"}, ak, hit);
      send_byte(d, dk, hit, d);
      check(dk == hit, {req, " data ack"}, dk, hit);
      bus_stop();
   endtask

   task automatic check_sel(string req);
      tick(3);
      check(sel1 == 8'(exp1(exp_reg, pwr)), {req, " sel1"}, sel1, exp1(exp_reg, pwr));
      check(sel2 == 3'(exp2(exp_reg, pwr)), {req, " sel2"}, sel2, exp2(exp_reg, pwr));
   endtask

   initial begin
      bit ak;
      logic [7:0] rb;
      tick(5);
      rst_n = 1;
      tick(5);
      // R3: reset state
      check(sel1 == 8'h01, "R3 sel1 reset", sel1, 1);
      check(sel2 == 3'h1, "R3 sel2 reset", sel2, 1);
      check(sda_oe == 1'b0, "R3 sda released", sda_oe, 0);

      // R1, R2, R4, R5: every select code with junk in low bits
      for (int code = 0; code < 8; code++) begin
         write_reg(8'h94, 8'((code << 5) | 5'h15), code < 5 ? "R4" : "R5");
         check_sel(code < 5 ? "R4 code" : "R5 code");
      end

      // R8: read twice (master ACK then NACK), then line stays released
      bus_start();
      send_byte(8'h95, ak, 0, 0);
      check(ak, "R1 read addr ack", ak, 1);
      recv_byte(rb, 1);
      check(rb == 8'(exp_reg), "R8 first read", rb, exp_reg);
      recv_byte(rb, 0);
      check(rb == 8'(exp_reg), "R8 repeat read", rb, exp_reg);
      tick(Q);
      check(sda_oe == 1'b0, "R8 release after NACK", sda_oe, 0);
      scl_m = 1; tick(Q); scl_m = 0; tick(Q);
      check(sda_oe == 1'b0, "R8 silent after NACK", sda_oe, 0);
      bus_stop();

      // R11: foreign address ignored
      write_reg(8'h96, 8'h00, "R11");
      check_sel("R11 unchanged");

      // R1: strap high moves the address
      strap = 1;
      write_reg(8'h96, 8'h40, "R1 strap");
      check_sel("R1 strap");
      write_reg(8'h94, 8'hE0, "R1 strap mismatch");
      check_sel("R1 strap mismatch");
      strap = 0;

      // R9: STOP in the middle of the data byte
      bus_start();
      send_byte(8'h94, ak, 0, 0);
      send_bits(8'hA0, 4);
      bus_stop();
      check_sel("R9 abort");

      // R10: repeated START mid-byte, then a full write
      bus_start();
      send_byte(8'h94, ak, 0, 0);
      send_bits(8'h20, 3);
      bus_start();
      send_byte(8'h94, ak, 0, 0);
      check(ak, "R10 readdress ack", ak, 1);
      send_byte(8'hC0, ak, 1, 8'hC0);
      bus_stop();
      check_sel("R10 restart");

      // R10/R11: wrong address then repeated START to a matching one
      bus_start();
      send_byte(8'hA0, ak, 0, 0);
      check(!ak, "R11 no ack", ak, 0);
      bus_start();
      send_byte(8'h94, ak, 0, 0);
      check(ak, "R10 ack after restart", ak, 1);
      send_byte(8'h80, ak, 1, 8'h80);
      bus_stop();
      check_sel("R10 after nack");

      // R6, R7: mute, write during mute, detect choice
      pwr = 0;
      check_sel("R6 mute");
      write_reg(8'h94, 8'hA0, "R6");
      check_sel("R6 write while muted");
      det = 1; tick(2);
      check(dtap == 2'b10, "R7 luma tap muted", dtap, 2);
      pwr = 1;
      check_sel("R6 unmute");
      det = 0; tick(2);
      check(dtap == 2'b01, "R7 composite tap", dtap, 1);

      tick(20);
      finish_run();
   end
endmodule